// File: doc/BRIEF.md
# Vectoring Interrupt Controller

The block gathers sixteen interrupt requests into a single interrupt line for a processor core, along with a code that identifies the request to service first. Eight requests arrive on active-low pins from outside the chip. Eight more come from on-chip sources as active-high levels. Each external pin can be set to latch a falling edge or to follow its level. Sources can be masked individually. An interrupt handler reads the code and uses it directly as an offset into a jump table.

How a request is cleared depends on its kind. A latched edge stays pending until software writes a 1 to its pending bit. A request in level mode, and every on-chip request, simply follows its source, so it has to be removed at the device that raised it. Each external pin can also be allowed to raise its own wake-up flag while it is pending.

A small register port gives access to four words: pending, mask, configuration and vector. Writes take effect at the clock edge where the write is strobed. Reads are combinational on the address.

Top module: `intc_top`

## Requirements
- R1: After reset, the pending, mask and configuration words read 0, `core_irq_o` is 0, `wake_o` is 0 and the vector is 0x40.
- R2: Register map: address 0 is pending (write-one-to-clear), 1 is mask, 2 is configuration and 3 is the vector (read-only, zero-extended). In the pending and mask words, bit 2k belongs to external pin k and bit 2k+1 to on-chip source k.
- R3: On-chip bit 2k+1 equals `lvl_i[k]` from the previous clock. Writing to the pending word does not change it.
- R4: In configuration bit k, 0 selects level mode for pin k. In level mode, pending bit 2k equals the inverse of `irq_n_i[k]` three clocks earlier (two synchronizer stages plus the pending register). A write to that bit has no effect.
- R5: When configuration bit k is 1 (edge mode), a falling edge on `irq_n_i[k]` sets pending bit 2k three clocks after the pin falls. The bit stays set after the pin returns high.
- R6: An edge-mode bit is cleared by a pending-word write with that bit at 1. A write with the bit at 0 leaves it set.
- R7: If an edge sets a bit in the same clock that a write clears it, the bit ends up set.
- R8: Only bits set in both the pending and mask words can raise `core_irq_o` or appear in the vector.
- R9: Priority runs from bit 0 (highest) to bit 15. The vector is 4 times the index of the highest-priority active bit, so pin 0 gives 0x00, on-chip 0 gives 0x04 and on-chip 7 gives 0x3C. When no bit is active, the vector is 0x40.
- R10: `core_irq_o` is a register. It equals the OR of (pending AND mask) as it stood on the previous clock.
- R11: `wake_o[k]` is 1 exactly when configuration bit 8+k is 1 and pending bit 2k is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| irq_n_i | input | 8 | External requests, active low, asynchronous |
| lvl_i | input | 8 | On-chip requests, active high, synchronous |
| bus_sel_i | input | 1 | Register access select |
| bus_wr_i | input | 1 | Write strobe, valid with `bus_sel_i` |
| bus_addr_i | input | 2 | Register address |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data for `bus_addr_i` |
| core_irq_o | output | 1 | Interrupt request to the core |
| vector_o | output | 8 | Code of the highest-priority active source |
| wake_o | output | 8 | Wake-up flag for each external pin |

## Verification
The hardest case to reach is a pin edge and a clearing write landing in the same clock. The pin passes through two synchronizer stages and an edge detector before it reaches the pending register. The bench therefore lowers the pin, counts off two rising edges, and then strobes the write so that it commits at the third edge, exactly when the edge sets the bit. Priority, masking and vector codes are covered by a table of level-mode pin patterns. Latching, clearing and the rules about which bits ignore writes are covered by directed sequences that read the pending word back over the register port.

// File: rtl/intc_pkg.sv
`timescale 1ns/1ps
package intc_pkg;
  typedef enum logic [1:0] {
    RA_PEND = 2'd0,
    RA_MASK = 2'd1,
    RA_CFG  = 2'd2,
    RA_VEC  = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/intc_sync_edge.sv
`timescale 1ns/1ps
module intc_sync_edge #(
  parameter int N_PIN = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_PIN-1:0] pin_n,
  output logic [N_PIN-1:0] active,
  output logic [N_PIN-1:0] fall
);
  for (genvar g = 0; g < N_PIN; g++) begin : g_pin
    logic s1_q, s2_q, prev_q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        s1_q   <= 1'b1;
        s2_q   <= 1'b1;
        prev_q <= 1'b1;
      end else begin
        s1_q   <= pin_n[g];
        s2_q   <= s1_q;
        prev_q <= s2_q;
      end
    end
    assign active[g] = ~s2_q;
    assign fall[g]   = prev_q & ~s2_q;
  end
endmodule

// File: rtl/intc_pend.sv
`timescale 1ns/1ps
module intc_pend #(
  parameter int N_PAIR = 8,
  localparam int NSRC = 2 * N_PAIR
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_PAIR-1:0] ext_active,
  input  logic [N_PAIR-1:0] ext_fall,
  input  logic [N_PAIR-1:0] edge_mode,
  input  logic [N_PAIR-1:0] int_req,
  input  logic              clr_we,
  input  logic [N_PAIR-1:0] ext_clr,
  output logic [NSRC-1:0]   pend
);
  for (genvar k = 0; k < N_PAIR; k++) begin : g_pair
    logic ext_q, int_q, ext_nxt;
    always_comb begin
      if (edge_mode[k])
        ext_nxt = ext_fall[k] | (ext_q & ~(clr_we & ext_clr[k]));
      else
        ext_nxt = ext_active[k];
    end
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ext_q <= 1'b0;
        int_q <= 1'b0;
      end else begin
        ext_q <= ext_nxt;
        int_q <= int_req[k];
      end
    end
    assign pend[2*k]   = ext_q;
    assign pend[2*k+1] = int_q;
  end
endmodule

// File: rtl/intc_prio.sv
`timescale 1ns/1ps
module intc_prio #(
  parameter int NSRC     = 16,
  parameter int VEC_W    = 8,
  parameter int VEC_STEP = 4
) (
  input  logic [NSRC-1:0]  active,
  output logic [VEC_W-1:0] vec,
  output logic             any
);
  localparam int IDLE = NSRC * VEC_STEP;
  always_comb begin
    vec = VEC_W'(IDLE);
    any = 1'b0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (active[i]) begin
        vec = VEC_W'(i * VEC_STEP);
        any = 1'b1;
      end
    end
  end
endmodule

// File: rtl/intc_top.sv
`timescale 1ns/1ps
module intc_top #(
  parameter int N_PAIR   = 8,
  parameter int VEC_W    = 8,
  parameter int VEC_STEP = 4,
  localparam int NSRC = 2 * N_PAIR
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_PAIR-1:0] irq_n_i,
  input  logic [N_PAIR-1:0] lvl_i,
  input  logic              bus_sel_i,
  input  logic              bus_wr_i,
  input  logic [1:0]        bus_addr_i,
  input  logic [NSRC-1:0]   bus_wdata_i,
  output logic [NSRC-1:0]   bus_rdata_o,
  output logic              core_irq_o,
  output logic [VEC_W-1:0]  vector_o,
  output logic [N_PAIR-1:0] wake_o
);
  import intc_pkg::*;

  logic [N_PAIR-1:0] ext_active, ext_fall, ext_clr;
  logic [NSRC-1:0]   pend_q, mask_q, cfg_q, live;
  logic              wr_en, any_live, core_q;
  logic [VEC_W-1:0]  vec;
  reg_addr_e         addr;

  assign addr  = reg_addr_e'(bus_addr_i);
  assign wr_en = bus_sel_i & bus_wr_i;

  intc_sync_edge #(.N_PIN(N_PAIR)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_n(irq_n_i),
    .active(ext_active), .fall(ext_fall)
  );

  for (genvar k = 0; k < N_PAIR; k++) begin : g_clr
    assign ext_clr[k] = bus_wdata_i[2*k];
  end

  intc_pend #(.N_PAIR(N_PAIR)) u_pend (
    .clk(clk), .rst_n(rst_n),
    .ext_active(ext_active), .ext_fall(ext_fall),
    .edge_mode(cfg_q[N_PAIR-1:0]), .int_req(lvl_i),
    .clr_we(wr_en && addr == RA_PEND), .ext_clr(ext_clr),
    .pend(pend_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= '0;
      cfg_q  <= '0;
      core_q <= 1'b0;
    end else begin
      if (wr_en && addr == RA_MASK) mask_q <= bus_wdata_i;
      if (wr_en && addr == RA_CFG)  cfg_q  <= bus_wdata_i;
      core_q <= any_live;
    end
  end

  assign live = pend_q & mask_q;

  intc_prio #(.NSRC(NSRC), .VEC_W(VEC_W), .VEC_STEP(VEC_STEP)) u_prio (
    .active(live), .vec(vec), .any(any_live)
  );

  for (genvar k = 0; k < N_PAIR; k++) begin : g_wake
    assign wake_o[k] = cfg_q[N_PAIR+k] & pend_q[2*k];
  end

  always_comb begin
    case (addr)
      RA_PEND: bus_rdata_o = pend_q;
      RA_MASK: bus_rdata_o = mask_q;
      RA_CFG:  bus_rdata_o = cfg_q;
      default: bus_rdata_o = NSRC'(vec);
    endcase
  end

  assign core_irq_o = core_q;
  assign vector_o   = vec;
endmodule

// File: rtl/intc_checks.sv
`timescale 1ns/1ps
module intc_checks #(
  parameter int N_PAIR   = 8,
  parameter int VEC_W    = 8,
  parameter int VEC_STEP = 4,
  localparam int NSRC = 2 * N_PAIR
) (
  input logic              clk,
  input logic              rst_n,
  input logic [N_PAIR-1:0] lvl_i,
  input logic [NSRC-1:0]   pend,
  input logic [NSRC-1:0]   mask,
  input logic [NSRC-1:0]   cfg,
  input logic              core_irq,
  input logic [VEC_W-1:0]  vector,
  input logic [N_PAIR-1:0] wake
);
  localparam int IDLE = NSRC * VEC_STEP;
  logic [NSRC-1:0] live;
  assign live = pend & mask;

  assert_core_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
    core_irq == $past(|live));

  assert_idle_code_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (live == '0) |-> (vector == VEC_W'(IDLE)));

  assert_vector_hits_live_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (vector != VEC_W'(IDLE)) |-> live[int'(vector) / VEC_STEP]);

  assert_wake_gated_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (wake & ~cfg[NSRC-1:N_PAIR]) == '0);

  for (genvar k = 0; k < N_PAIR; k++) begin : g_lvl
    assert_onchip_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
      pend[2*k+1] == $past(lvl_i[k]));
  end
endmodule

bind intc_top intc_checks #(.N_PAIR(N_PAIR), .VEC_W(VEC_W), .VEC_STEP(VEC_STEP)) u_checks (
  .clk(clk), .rst_n(rst_n), .lvl_i(lvl_i), .pend(pend_q), .mask(mask_q),
  .cfg(cfg_q), .core_irq(core_irq_o), .vector(vector_o), .wake(wake_o)
);

// File: tb/test_intc_top.sv
`timescale 1ns/1ps
module test_intc_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  irq_n = 8'hFF;
  logic [7:0]  lvl = 8'h00;
  logic        sel = 1'b0, wr = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        core_irq;
  logic [7:0]  vec, wake;
  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  intc_top i_intc_top (
    .clk(clk), .rst_n(rst_n), .irq_n_i(irq_n), .lvl_i(lvl),
    .bus_sel_i(sel), .bus_wr_i(wr), .bus_addr_i(addr), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .core_irq_o(core_irq), .vector_o(vec), .wake_o(wake)
  );

  typedef struct packed {
    logic [7:0]  pins_n;
    logic [7:0]  onchip;
    logic [15:0] msk;
    logic [7:0]  exp_vec;
    logic        exp_irq;
  } row_t;

  // Level mode throughout; covers R8 and R9
  localparam row_t TBL [10] = '{
    '{8'hFF, 8'h00, 16'hFFFF, 8'h40, 1'b0},
    '{8'hFE, 8'h00, 16'hFFFF, 8'h00, 1'b1},
    '{8'hFF, 8'h01, 16'hFFFF, 8'h04, 1'b1},
    '{8'hFE, 8'h01, 16'hFFFF, 8'h00, 1'b1},
    '{8'h7F, 8'h80, 16'hFFFF, 8'h38, 1'b1},
    '{8'hFF, 8'h80, 16'hFFFF, 8'h3C, 1'b1},
    '{8'hF7, 8'h04, 16'hFFFF, 8'h14, 1'b1},
    '{8'hF7, 8'h04, 16'hFFDF, 8'h18, 1'b1},
    '{8'h00, 8'hFF, 16'h0000, 8'h40, 1'b0},
    '{8'h00, 8'hFF, 16'h8000, 8'h3C, 1'b1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    sel = 1'b0; wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [15:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  initial begin
    #2000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [15:0] d;
    wait_cyc(4);
    rst_n = 1'b1;
    wait_cyc(1);
    // R1 reset state
    rd_reg(2'd0, d); chk("R1 pend", d, 0);
    rd_reg(2'd1, d); chk("R1 mask", d, 0);
    rd_reg(2'd2, d); chk("R1 cfg", d, 0);
    rd_reg(2'd3, d); chk("R1 vec reg", d, 16'h0040);
    chk("R1 irq", core_irq, 0);
    chk("R1 wake", wake, 0);

    foreach (TBL[i]) begin
      wr_reg(2'd1, TBL[i].msk);
      irq_n = TBL[i].pins_n;
      lvl = TBL[i].onchip;
      wait_cyc(5);
      chk("R9 vector", vec, TBL[i].exp_vec);
      chk("R8 core irq", core_irq, TBL[i].exp_irq);
      rd_reg(2'd3, d); chk("R2 vector read", d, {8'h00, TBL[i].exp_vec});
    end

    irq_n = 8'hFF; lvl = 8'h00;
    wr_reg(2'd1, 16'h0000);
    wait_cyc(5);

    // R10 registered core irq: mask update at P1, irq at P2
    lvl[0] = 1'b1;
    wait_cyc(3);
    @(negedge clk);
    sel = 1'b1; wr = 1'b1; addr = 2'd1; wdata = 16'h0002;
    @(posedge clk);
    @(negedge clk);
    sel = 1'b0; wr = 1'b0;
    chk("R10 irq one clock after mask", core_irq, 0);
    @(negedge clk);
    chk("R10 irq asserted", core_irq, 1);
    lvl[0] = 1'b0;
    wr_reg(2'd1, 16'hFFFF);
    wait_cyc(3);

    // R5/R6 edge mode on pin 0
    wr_reg(2'd2, 16'h0001);
    irq_n[0] = 1'b0;
    wait_cyc(5);
    rd_reg(2'd0, d); chk("R5 edge latched", d[0], 1);
    irq_n[0] = 1'b1;
    wait_cyc(5);
    rd_reg(2'd0, d); chk("R5 stays after pin high", d[0], 1);
    wr_reg(2'd0, 16'hFFFE);
    rd_reg(2'd0, d); chk("R6 zero write keeps bit", d[0], 1);
    wr_reg(2'd0, 16'h0001);
    rd_reg(2'd0, d); chk("R6 w1c clears", d[0], 0);
    chk("R6 vector idle", vec, 8'h40);

    // R7 edge and clear in the same clock
    irq_n[0] = 1'b0;
    wait_cyc(5);
    irq_n[0] = 1'b1;
    wait_cyc(5);
    @(negedge clk);
    irq_n[0] = 1'b0;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    sel = 1'b1; wr = 1'b1; addr = 2'd0; wdata = 16'h0001;
    @(posedge clk);
    @(negedge clk);
    sel = 1'b0; wr = 1'b0;
    rd_reg(2'd0, d); chk("R7 edge wins", d[0], 1);
    wr_reg(2'd0, 16'h0001);
    rd_reg(2'd0, d); chk("R7 later clear", d[0], 0);
    irq_n[0] = 1'b1;

    // R4 level pin ignores writes
    irq_n[1] = 1'b0;
    wait_cyc(5);
    rd_reg(2'd0, d); chk("R4 level pending", d[2], 1);
    wr_reg(2'd0, 16'h0004);
    rd_reg(2'd0, d); chk("R4 write ignored", d[2], 1);

    // R11 wake flags
    wr_reg(2'd2, 16'h0201);
    chk("R11 wake on", wake, 8'h02);
    wr_reg(2'd2, 16'h0001);
    chk("R11 wake off", wake, 8'h00);
    wr_reg(2'd2, 16'h0201);
    irq_n[1] = 1'b1;
    wait_cyc(5);
    rd_reg(2'd0, d); chk("R4 follows pin", d[2], 0);
    chk("R11 wake idle pin", wake, 8'h00);

    // R3 on-chip bit not clearable
    lvl[3] = 1'b1;
    wait_cyc(2);
    wr_reg(2'd0, 16'h0080);
    rd_reg(2'd0, d); chk("R3 onchip kept", d[7], 1);
    lvl[3] = 1'b0;
    wait_cyc(2);
    rd_reg(2'd0, d); chk("R3 onchip follows", d[7], 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule